// File: doc/BRIEF.md
# I2C Pointer-Addressed Control Register Target

This block is an I2C bus target that holds a handful of motor-driver control bytes. It sits behind a fixed 7-bit bus address. It keeps an internal byte pointer that selects which register a transfer touches. A write transfer always carries a fresh pointer byte first, followed by data bytes. A read transfer needs no pointer phase, because it starts at whatever the pointer already holds. To read from a different location, the controller sends the pointer in a write and then issues a repeated START with the read bit set. The pointer steps forward by one after every byte that is stored, and after every read byte that the controller acknowledges.

Both bus lines are oversampled by a fast system clock. Each line passes through a two-flop synchroniser and then a stability filter, and only then are edges detected. SDA is open-drain: the `sda_oe` output means "pull the line low". The control bytes appear as decoded fields on plain output pins. Three health flags come in on plain input pins, and a read-only byte returns their live values. Clock stretching and high-speed mode are not supported.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, the register at 0x20 holds 0x90, the register at 0x21 holds 0x2C, and the pointer holds 0x20. A read with no pointer phase therefore returns 0x90.
- R2: The target acknowledges only the bus address 7'h06. The bit after the address selects the direction: 0 for write, 1 for read. Any other address gets no ACK, and the target leaves SDA alone until the next START or STOP.
- R3: In a write, the first byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then increments. Every one of these bytes is acknowledged.
- R4: A read sends the byte at the pointer, MSB first, beginning on the SCL low phase after the address ACK. A controller ACK increments the pointer and starts the next byte. A controller NACK makes the target release SDA, and the pointer does not move.
- R5: The pointer keeps its value from one transaction to the next.
- R6: A repeated START right after a pointer byte begins a new address phase, and no register is written.
- R7: The byte at 0x22 is read-only. Bit 3 is `supply_ok`, bit 2 is `vreg_ok`, bit 1 is `temp_ok`, and the other bits read 0. It shows the values of those pins at the time the byte is read. A write to 0x22 is acknowledged and discarded.
- R8: A write to any address other than 0x20–0x22 is acknowledged and discarded. A read from such an address returns 0x00.
- R9: If a byte written to 0x21 has bits 4:2 equal to 3'b111, those bits are stored as 3'b110.
- R10: The outputs decode the control bytes as follows. In 0x20, bit 7 drives `drive_en`, bit 6 drives `boost_en` and bit 5 drives `boost_high`. In 0x21, bits 7:5 drive `gain_code` and bits 4:2 drive `vreg_code`.
- R11: `sda_oe` is asserted only while the filtered SCL is low, and it is low in the cycle after a STOP.
- R12: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks is ignored. A 2-clock SCL dip during a high phase adds no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| supply_ok | input | 1 | Supply above its lockout threshold |
| vreg_ok | input | 1 | Regulator output in range |
| temp_ok | input | 1 | Thermal trip not active |
| drive_en | output | 1 | Drive enable field |
| boost_en | output | 1 | Over-drive enable field |
| boost_high | output | 1 | Over-drive polarity select field |
| gain_code | output | 3 | Gain resistor code |
| vreg_code | output | 3 | Regulator voltage code (never 3'b111) |

## Verification
Several actions can happen on the same byte boundary. On the 8th SCL rise of a data byte, the target stores the byte, applies the voltage-code clamp or the read-only discard, and advances the pointer, all in one cycle. The bench provokes this with a burst write that starts at 0x21 and runs on into 0x22. It then judges the result by reading back 0x21, 0x22 and 0x23 in one acknowledged burst, which must return 0xF8, the live status byte and 0x00. A second collision is a repeated START arriving where a data byte would have begun. This is judged by checking that the register at the pointer is unchanged and can be read back.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam logic [6:0] TGT_ADDR   = 7'h06;
  localparam logic [7:0] BASE_ADDR  = 8'h20;
  localparam logic [7:0] CTRL0_INIT = 8'h90;
  localparam logic [7:0] CTRL1_INIT = 8'h2C;
  localparam logic [2:0] VREG_TOP   = 3'b110;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_SKIP
  } tgt_state_e;

  typedef enum logic [1:0] {
    K_ADDR, K_PTR, K_DATA, K_READ
  } byte_kind_e;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int STABLE = 3,
  parameter bit INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(STABLE + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  // Two-flop synchroniser, then the output follows only after
  // STABLE consecutive samples that differ from it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= {2{INIT}};
      clean <= INIT;
      cnt   <= '0;
    end else begin
      sync <= {sync[0], raw};
      if (sync[1] != clean) begin
        if (cnt == CW'(STABLE - 1)) begin
          clean <= sync[1];
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    scl_rise  = scl & ~scl_q;
    scl_fall  = ~scl & scl_q;
    start_evt = scl & scl_q & sda_q & ~sda;
    stop_evt  = scl & scl_q & ~sda_q & sda;
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_tgt_pkg::*;
#(
  parameter logic [7:0] BASE  = BASE_ADDR,
  parameter logic [7:0] INIT0 = CTRL0_INIT,
  parameter logic [7:0] INIT1 = CTRL1_INIT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic [2:0] stat_bits,
  output logic       drive_en,
  output logic       boost_en,
  output logic       boost_high,
  output logic [2:0] gain_code,
  output logic [2:0] vreg_code
);
  localparam logic [7:0] OFS_C0 = BASE;
  localparam logic [7:0] OFS_C1 = BASE + 8'd1;
  localparam logic [7:0] OFS_ST = BASE + 8'd2;

  logic [7:0] ctrl0, ctrl1;
  logic [7:0] c1_fixed;

  // Voltage code 3'b111 is out of range and is stored as VREG_TOP.
  always_comb begin
    c1_fixed = wr_data;
    if (wr_data[4:2] == 3'b111) c1_fixed[4:2] = VREG_TOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0 <= INIT0;
      ctrl1 <= INIT1;
    end else if (wr_en) begin
      if (wr_addr == OFS_C0) ctrl0 <= wr_data;
      if (wr_addr == OFS_C1) ctrl1 <= c1_fixed;
    end
  end

  always_comb begin
    case (rd_addr)
      OFS_C0:  rd_data = ctrl0;
      OFS_C1:  rd_data = ctrl1;
      OFS_ST:  rd_data = {4'b0000, stat_bits, 1'b0};
      default: rd_data = 8'h00;
    endcase
  end

  assign drive_en   = ctrl0[7];
  assign boost_en   = ctrl0[6];
  assign boost_high = ctrl0[5];
  assign gain_code  = ctrl1[7:5];
  assign vreg_code  = ctrl1[4:2];
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = TGT_ADDR,
  parameter logic [7:0] PTR_INIT = BASE_ADDR
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       sda_f,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] ptr
);
  tgt_state_e state;
  byte_kind_e kind, nxt;
  logic [2:0] bitcnt;
  logic [6:0] shreg;
  logic [6:0] tx_sh;
  logic       flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      kind    <= K_ADDR;
      nxt     <= K_ADDR;
      bitcnt  <= '0;
      shreg   <= '0;
      tx_sh   <= '0;
      flag    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      ptr     <= PTR_INIT;
    end else begin
      wr_en <= 1'b0;
      if (stop_evt) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        state  <= S_RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_RX: if (scl_rise) begin
            shreg  <= {shreg[5:0], sda_f};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 3'd7) begin
              flag  <= 1'b0;
              state <= S_ACK;
              case (kind)
                K_ADDR: begin
                  if (shreg == DEV_ADDR) nxt <= sda_f ? K_READ : K_PTR;
                  else                   state <= S_SKIP;
                end
                K_PTR: begin
                  ptr <= {shreg, sda_f};
                  nxt <= K_DATA;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= {shreg, sda_f};
                  ptr     <= ptr + 8'd1;
                  nxt     <= K_DATA;
                end
              endcase
            end
          end
          S_ACK: if (scl_fall) begin
            if (!flag) begin
              sda_oe <= 1'b1;
              flag   <= 1'b1;
            end else begin
              flag   <= 1'b0;
              bitcnt <= '0;
              if (nxt == K_READ) begin
                tx_sh  <= rd_data[6:0];
                sda_oe <= ~rd_data[7];
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                kind   <= nxt;
                state  <= S_RX;
              end
            end
          end
          S_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              flag   <= 1'b0;
              state  <= S_MACK;
            end else begin
              sda_oe <= ~tx_sh[6];
              tx_sh  <= {tx_sh[5:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
          S_MACK: begin
            if (scl_rise && !flag) begin
              if (!sda_f) begin
                ptr  <= ptr + 8'd1;
                flag <= 1'b1;
              end else begin
                state <= S_SKIP;
              end
            end else if (scl_fall && flag) begin
              flag   <= 1'b0;
              tx_sh  <= rd_data[6:0];
              sda_oe <= ~rd_data[7];
              state  <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = TGT_ADDR,
  parameter logic [7:0] REG_BASE  = BASE_ADDR,
  parameter logic [7:0] CTRL0_RST = CTRL0_INIT,
  parameter logic [7:0] CTRL1_RST = CTRL1_INIT,
  parameter int         FILT_LEN  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       supply_ok,
  input  logic       vreg_ok,
  input  logic       temp_ok,
  output logic       drive_en,
  output logic       boost_en,
  output logic       boost_high,
  output logic [2:0] gain_code,
  output logic [2:0] vreg_code
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_en;
  logic [7:0] wr_addr, wr_data, ptr, rd_data;

  assign raw_lines = {sda_in, scl_in};

  for (genvar i = 0; i < NLINES; i++) begin : g_filt
    i2c_line_filter #(.STABLE(FILT_LEN), .INIT(1'b1)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines[i]),
      .clean(clean_lines[i])
    );
  end

  assign scl_f = clean_lines[0];
  assign sda_f = clean_lines[1];

  i2c_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_f),
    .sda      (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_INIT(REG_BASE)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_f    (sda_f),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ptr      (ptr)
  );

  i2c_reg_bank #(.BASE(REG_BASE), .INIT0(CTRL0_RST), .INIT1(CTRL1_RST)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (ptr),
    .rd_data   (rd_data),
    .stat_bits ({supply_ok, vreg_ok, temp_ok}),
    .drive_en  (drive_en),
    .boost_en  (boost_en),
    .boost_high(boost_high),
    .gain_code (gain_code),
    .vreg_code (vreg_code)
  );
endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       stop_evt,
  input logic       sda_oe,
  input logic       wr_en,
  input logic       drive_en,
  input logic       boost_en,
  input logic       boost_high,
  input logic [2:0] gain_code,
  input logic [2:0] vreg_code
);
  assert_vreg_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_code != 3'b111);

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({drive_en, boost_en, boost_high, gain_code, vreg_code}));

  assert_pull_while_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$stable(sda_oe)) |-> !scl_f);

  assert_release_on_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);
endmodule

bind i2c_regfile_target i2c_regfile_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_f     (scl_f),
  .stop_evt  (stop_evt),
  .sda_oe    (sda_oe),
  .wr_en     (wr_en),
  .drive_en  (drive_en),
  .boost_en  (boost_en),
  .boost_high(boost_high),
  .gain_code (gain_code),
  .vreg_code (vreg_code)
);

// File: tb/sim_i2c_regfile_target.sv
module sim_i2c_regfile_target;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, scl_glitch = 1'b0;
  logic supply_ok = 1'b1, vreg_ok = 1'b1, temp_ok = 1'b1;
  logic sda_oe, drive_en, boost_en, boost_high;
  logic [2:0] gain_code, vreg_code;
  wire scl_bus = scl_m & ~scl_glitch;
  wire sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  i2c_regfile_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus), .sda_oe(sda_oe),
    .supply_ok(supply_ok), .vreg_ok(vreg_ok), .temp_ok(temp_ok),
    .drive_en(drive_en), .boost_en(boost_en), .boost_high(boost_high),
    .gain_code(gain_code), .vreg_code(vreg_code)
  );

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic wr_byte(input logic [7:0] b, input int gbit, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitq();
      scl_m = 1'b1;
      if (i == gbit) begin
        repeat (6) @(negedge clk);
        scl_glitch = 1'b1;
        repeat (2) @(negedge clk);
        scl_glitch = 1'b0;
        repeat (Q - 8) @(negedge clk);
      end else begin
        waitq();
      end
      waitq();
      scl_m = 1'b0; waitq();
    end
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    ack = (sda_bus == 1'b0);
    waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq();
      scl_m = 1'b1; waitq();
      b[i] = sda_bus;
      waitq();
      scl_m = 1'b0; waitq();
    end
    sda_m = mack ? 1'b0 : 1'b1; waitq();
    scl_m = 1'b1; waitq(); waitq();
    scl_m = 1'b0; waitq();
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1", "drive_en", 8'(drive_en), 8'h01);
    chk("R10", "boost_en", 8'(boost_en), 8'h00);
    chk("R10", "boost_high", 8'(boost_high), 8'h00);
    chk("R1", "gain_code", 8'(gain_code), 8'h01);
    chk("R1", "vreg_code", 8'(vreg_code), 8'h03);
    chk("R11", "sda_oe idle", 8'(sda_oe), 8'h00);
  endtask

  task automatic t_plain_read_default();
    bit a; logic [7:0] d;
    i2c_start();
    wr_byte(8'h0D, -1, a); chk("R2", "read addr ack", 8'(a), 8'h01);
    rd_byte(1'b0, d);      chk("R1", "default read", d, 8'h90);
    i2c_stop();
    chk("R11", "released after stop", 8'(sda_oe), 8'h00);
  endtask

  task automatic t_write_one();
    bit a;
    i2c_start();
    wr_byte(8'h0C, -1, a); chk("R2", "write addr ack", 8'(a), 8'h01);
    wr_byte(8'h20, -1, a); chk("R3", "pointer ack", 8'(a), 8'h01);
    wr_byte(8'h60, -1, a); chk("R3", "data ack", 8'(a), 8'h01);
    i2c_stop();
    chk("R10", "drive_en", 8'(drive_en), 8'h00);
    chk("R10", "boost_en", 8'(boost_en), 8'h01);
    chk("R10", "boost_high", 8'(boost_high), 8'h01);
  endtask

  task automatic t_write_burst();
    bit a;
    i2c_start();
    wr_byte(8'h0C, -1, a);
    wr_byte(8'h21, -1, a);
    wr_byte(8'hFC, -1, a); chk("R3", "burst byte0 ack", 8'(a), 8'h01);
    wr_byte(8'hAA, -1, a); chk("R7", "read-only write ack", 8'(a), 8'h01);
    i2c_stop();
    chk("R10", "gain_code", 8'(gain_code), 8'h07);
    chk("R9", "vreg clamp", 8'(vreg_code), 8'h06);
  endtask

  task automatic t_read_burst();
    bit a; logic [7:0] d;
    supply_ok = 1'b1; vreg_ok = 1'b0; temp_ok = 1'b1;
    i2c_start();
    wr_byte(8'h0C, -1, a);
    wr_byte(8'h21, -1, a);
    i2c_start();
    wr_byte(8'h0D, -1, a); chk("R6", "restart addr ack", 8'(a), 8'h01);
    rd_byte(1'b1, d); chk("R4", "burst 0x21", d, 8'hF8);
    rd_byte(1'b1, d); chk("R7", "status byte", d, 8'h0A);
    rd_byte(1'b0, d); chk("R8", "unimplemented read", d, 8'h00);
    i2c_stop();
  endtask

  task automatic t_ptr_kept();
    bit a; logic [7:0] d;
    i2c_start();
    wr_byte(8'h0C, -1, a);
    wr_byte(8'h22, -1, a);
    i2c_start();
    wr_byte(8'h0D, -1, a);
    rd_byte(1'b0, d); chk("R7", "status A", d, 8'h0A);
    i2c_stop();
    supply_ok = 1'b1; vreg_ok = 1'b1; temp_ok = 1'b0;
    i2c_start();
    wr_byte(8'h0D, -1, a);
    rd_byte(1'b0, d); chk("R5", "pointer kept, live status", d, 8'h0C);
    i2c_stop();
    i2c_start();
    wr_byte(8'h0D, -1, a);
    rd_byte(1'b0, d); chk("R4", "NACK leaves pointer", d, 8'h0C);
    i2c_stop();
  endtask

  task automatic t_restart_no_write();
    bit a; logic [7:0] d;
    i2c_start();
    wr_byte(8'h0C, -1, a);
    wr_byte(8'h20, -1, a);
    i2c_start();
    wr_byte(8'h0D, -1, a);
    rd_byte(1'b0, d); chk("R6", "read after restart", d, 8'h60);
    i2c_stop();
    chk("R6", "drive_en unchanged", 8'(drive_en), 8'h00);
  endtask

  task automatic t_bad_addr();
    bit a;
    i2c_start();
    wr_byte(8'h0E, -1, a); chk("R2", "foreign addr nack", 8'(a), 8'h00);
    wr_byte(8'h20, -1, a); chk("R2", "ignored byte nack", 8'(a), 8'h00);
    wr_byte(8'h00, -1, a); chk("R2", "ignored byte2 nack", 8'(a), 8'h00);
    i2c_stop();
    chk("R2", "drive_en untouched", 8'(drive_en), 8'h00);
    chk("R2", "boost_en untouched", 8'(boost_en), 8'h01);
  endtask

  task automatic t_unimpl();
    bit a; logic [7:0] d;
    i2c_start();
    wr_byte(8'h0C, -1, a);
    wr_byte(8'h40, -1, a); chk("R8", "pointer 0x40 ack", 8'(a), 8'h01);
    wr_byte(8'h55, -1, a); chk("R8", "discarded write ack", 8'(a), 8'h01);
    i2c_stop();
    chk("R8", "gain after discard", 8'(gain_code), 8'h07);
    chk("R8", "vreg after discard", 8'(vreg_code), 8'h06);
    i2c_start();
    wr_byte(8'h0C, -1, a);
    wr_byte(8'h40, -1, a);
    i2c_start();
    wr_byte(8'h0D, -1, a);
    rd_byte(1'b0, d); chk("R8", "read 0x40", d, 8'h00);
    i2c_stop();
  endtask

  task automatic t_glitch();
    bit a;
    i2c_start();
    wr_byte(8'h0C, 2, a); chk("R12", "addr ack with glitch", 8'(a), 8'h01);
    wr_byte(8'h20, 5, a); chk("R12", "pointer ack with glitch", 8'(a), 8'h01);
    wr_byte(8'h80, 0, a); chk("R12", "data ack with glitch", 8'(a), 8'h01);
    i2c_stop();
    chk("R12", "drive_en", 8'(drive_en), 8'h01);
    chk("R12", "boost_en", 8'(boost_en), 8'h00);
    chk("R12", "boost_high", 8'(boost_high), 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_plain_read_default();
    t_write_one();
    t_write_burst();
    t_read_burst();
    t_ptr_kept();
    t_restart_no_write();
    t_bad_addr();
    t_unimpl();
    t_glitch();
    repeat (20) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule